// File: doc/BRIEF.md
# Three-Channel Time-Division Link

This block carries three user samples over a single shared serial line by giving each user one slot in turn. A transmit half selects one user word per clock and places it on the outgoing line; a receive half, running its own slot count, routes each word arriving on the incoming line back to the matching user output. The outgoing and incoming lines are separate ports, so the block can be used with any channel between them: a direct wire, a pipeline stage, or a model of a longer path.

Both halves use a modulo-3 slot counter. The low count bit drives the low select bit and the high count bit drives the high select bit, on the transmit selector and on the receive router alike. The two counters share reset and a sync input, which returns both to slot 0 together. On the receive side, each user output is registered and has a one-cycle valid strobe. A frame register gathers the three words of one frame and presents them together once every three clocks.

Top module: `tdm3_link`

## Requirements
- R1: While reset is held, every receive word, every valid strobe and the frame strobe are 0, and the outgoing line carries user 0's word.
- R2: The slot count on each side steps 0, 1, 2, 0, ... one step per clock. Code 3 is never reached, and the next-state logic maps it to 0.
- R3: In slot s, the outgoing line equals user input s (bits s*W+W-1..s*W of `tx_user`). A change on any other user input does not affect the line during that slot.
- R4: At the clock edge that ends receive slot s, output word s (bits s*W+W-1..s*W of `rx_user`) loads `line_in`, and every other output word is cleared to 0.
- R5: After that same edge, `rx_valid` equals 1<<s for exactly one cycle. At most one valid bit is ever high.
- R6: A clock edge that samples `sync` high sends both slot counters to slot 0. That edge still completes the delivery for the slot that was current.
- R7: At the edge that ends receive slot 2, `frame_out` takes all three words of the frame, with word c at bits c*W+W-1..c*W. `frame_valid` is high for that one cycle only and coincides with `rx_valid[2]`.
- R8: The receive side routes by its own count only. A channel that delays the line by one clock therefore delivers user s-1's word (mod 3) on output s. This shows a one-slot misalignment at the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Realigns both slot counters to slot 0 |
| tx_user | input | 3*DATA_W | Three user words to send, user c at c*DATA_W |
| line_out | output | DATA_W | Shared line, transmit side |
| line_in | input | DATA_W | Shared line, receive side |
| rx_user | output | 3*DATA_W | Routed user words, registered |
| rx_valid | output | 3 | One-cycle strobe per user slot |
| frame_out | output | 3*DATA_W | Whole frame, updated once per three clocks |
| frame_valid | output | 1 | Strobe for a new frame |

## Verification
The first two patterns use words that differ from each other, for example 11/22/33 and FF/00/A5. With these, a swapped slot or a crossed select bit shows up as a wrong word on a named output, and a stuck data bit or an output that is not cleared shows up too. A third pattern changes the unselected inputs in the middle of a slot, which separates a clean selector from one that leaks other inputs. Two more scenarios check alignment: a sync pulse in the middle of a frame, and a channel with one clock of delay, whose words must land exactly one user later.

// File: rtl/tdm3_pkg.sv
`timescale 1ns/1ps
package tdm3_pkg;
   localparam int unsigned NUM_CH = 3;
   localparam int unsigned SLOT_W = 2;
   localparam int unsigned LAST_SLOT = NUM_CH - 1;
   typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/tdm3_slot_ctr.sv
`timescale 1ns/1ps
module tdm3_slot_ctr
   import tdm3_pkg::*;
#(
   parameter int unsigned LAST = LAST_SLOT
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sync,
   output slot_t slot
);
   if (LAST >= (1 << SLOT_W)) begin : g_bad_last
      $error("slot limit does not fit the slot code");
   end

   // count 0..LAST; any code above LAST (unreachable) folds back to 0
   always_ff @(posedge clk) begin
      if (!rst_n)
         slot <= '0;
      else if (sync || slot >= slot_t'(LAST))
         slot <= '0;
      else
         slot <= slot_t'(slot + 1'b1);
   end
endmodule

// File: rtl/tdm3_tx_mux.sv
`timescale 1ns/1ps
module tdm3_tx_mux
   import tdm3_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CH     = NUM_CH
) (
   input  logic [CH*DATA_W-1:0] din,
   input  slot_t                sel,
   output logic [DATA_W-1:0]    line
);
   // only the selected word reaches the line; unused code gives 0
   always_comb begin
      line = '0;
      for (int c = 0; c < int'(CH); c++) begin
         if (sel == slot_t'(c))
            line = din[c*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/tdm3_rx_demux.sv
`timescale 1ns/1ps
module tdm3_rx_demux
   import tdm3_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CH     = NUM_CH
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  slot_t                sel,
   input  logic [DATA_W-1:0]    line,
   output logic [CH*DATA_W-1:0] dout,
   output logic [CH-1:0]        valid
);
   for (genvar c = 0; c < CH; c++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dout[c*DATA_W +: DATA_W] <= '0;
            valid[c]                 <= 1'b0;
         end else if (sel == slot_t'(c)) begin
            dout[c*DATA_W +: DATA_W] <= line;
            valid[c]                 <= 1'b1;
         end else begin
            dout[c*DATA_W +: DATA_W] <= '0;
            valid[c]                 <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tdm3_frame_cap.sv
`timescale 1ns/1ps
module tdm3_frame_cap
   import tdm3_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CH     = NUM_CH
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  slot_t                sel,
   input  logic [DATA_W-1:0]    line,
   output logic [CH*DATA_W-1:0] frame,
   output logic                 frame_vld
);
   localparam int unsigned HOLD_N = CH - 1;
   localparam slot_t       LAST   = slot_t'(CH - 1);

   logic [DATA_W-1:0] hold [HOLD_N];

   for (genvar c = 0; c < HOLD_N; c++) begin : g_hold
      always_ff @(posedge clk) begin
         if (!rst_n)
            hold[c] <= '0;
         else if (sel == slot_t'(c))
            hold[c] <= line;
      end
      always_ff @(posedge clk) begin
         if (!rst_n)
            frame[c*DATA_W +: DATA_W] <= '0;
         else if (sel == LAST)
            frame[c*DATA_W +: DATA_W] <= hold[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame[HOLD_N*DATA_W +: DATA_W] <= '0;
         frame_vld                      <= 1'b0;
      end else begin
         frame_vld <= (sel == LAST);
         if (sel == LAST)
            frame[HOLD_N*DATA_W +: DATA_W] <= line;
      end
   end
endmodule

// File: rtl/tdm3_link.sv
`timescale 1ns/1ps
module tdm3_link
   import tdm3_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sync,
   input  logic [NUM_CH*DATA_W-1:0] tx_user,
   output logic [DATA_W-1:0]        line_out,
   input  logic [DATA_W-1:0]        line_in,
   output logic [NUM_CH*DATA_W-1:0] rx_user,
   output logic [NUM_CH-1:0]        rx_valid,
   output logic [NUM_CH*DATA_W-1:0] frame_out,
   output logic                     frame_valid
);
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (NUM_CH > (1 << SLOT_W)) begin : g_bad_ch
      $error("channel count exceeds slot code range");
   end

   slot_t tx_slot;
   slot_t rx_slot;

   tdm3_slot_ctr u_tx_ctr (.clk(clk), .rst_n(rst_n), .sync(sync), .slot(tx_slot));
   tdm3_slot_ctr u_rx_ctr (.clk(clk), .rst_n(rst_n), .sync(sync), .slot(rx_slot));

   tdm3_tx_mux #(.DATA_W(DATA_W)) u_mux (
      .din(tx_user), .sel(tx_slot), .line(line_out)
   );

   tdm3_rx_demux #(.DATA_W(DATA_W)) u_demux (
      .clk(clk), .rst_n(rst_n), .sel(rx_slot), .line(line_in),
      .dout(rx_user), .valid(rx_valid)
   );

   tdm3_frame_cap #(.DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .sel(rx_slot), .line(line_in),
      .frame(frame_out), .frame_vld(frame_valid)
   );
endmodule

// File: rtl/tdm3_link_chk.sv
`timescale 1ns/1ps
module tdm3_link_chk
   import tdm3_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     sync,
   input slot_t                    tx_slot,
   input slot_t                    rx_slot,
   input logic [NUM_CH*DATA_W-1:0] rx_user,
   input logic [NUM_CH-1:0]        rx_valid,
   input logic                     frame_valid
);
   logic [NUM_CH*DATA_W-1:0] idle_mask;
   always_comb begin
      for (int c = 0; c < int'(NUM_CH); c++)
         idle_mask[c*DATA_W +: DATA_W] = {DATA_W{~rx_valid[c]}};
   end

   // R2
   slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync && tx_slot == slot_t'(LAST_SLOT)) |=> tx_slot == '0);
   // R2
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_slot <= slot_t'(LAST_SLOT) && rx_slot <= slot_t'(LAST_SLOT));
   // R6
   sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> (tx_slot == '0 && rx_slot == '0));
   // R8
   slot_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_slot == rx_slot);
   // R5
   valid_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rx_valid));
   // R4
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_user & idle_mask) == '0);
   // R7
   frame_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> rx_valid[NUM_CH-1]);
   // R7
   frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);
endmodule

bind tdm3_link tdm3_link_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sync(sync), .tx_slot(tx_slot), .rx_slot(rx_slot),
   .rx_user(rx_user), .rx_valid(rx_valid), .frame_valid(frame_valid)
);

// File: tb/tdm3_link_test.sv
`timescale 1ns/1ps
module tdm3_link_test;
   localparam int W = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sync = 1'b0;
   logic [3*W-1:0] tx_user = '0;
   logic [W-1:0]  line_out, line_in, line_q;
   logic [3*W-1:0] rx_user, frame_out;
   logic [2:0]    rx_valid;
   logic          frame_valid;
   logic          dly = 1'b0;
   int            n_chk = 0;
   int            n_fail = 0;
   bit            done = 1'b0;

   always #2.5 clk = ~clk;

   always @(posedge clk) line_q <= line_out;
   assign line_in = dly ? line_q : line_out;

   tdm3_link #(.DATA_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .sync(sync), .tx_user(tx_user),
      .line_out(line_out), .line_in(line_in), .rx_user(rx_user),
      .rx_valid(rx_valid), .frame_out(frame_out), .frame_valid(frame_valid)
   );

   function automatic logic [3*W-1:0] put(logic [W-1:0] v, int s);
      logic [3*W-1:0] r = '0;
      r[s*W +: W] = v;
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_sync();
      @(negedge clk) sync = 1'b1;
      @(posedge clk);
      @(negedge clk) sync = 1'b0;
   endtask

   // R1: reset state
   task automatic t_reset();
      tx_user = {8'h0C, 8'h0B, 8'h0A};
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(rx_user == '0, "R1 rx_user", rx_user, 0);
      chk(rx_valid == '0, "R1 rx_valid", rx_valid, 0);
      chk(frame_valid == 1'b0, "R1 frame_valid", frame_valid, 0);
      chk(line_out == 8'h0A, "R1 line_out", line_out, 8'h0A);
      rst_n = 1'b1;
   endtask

   // R2 R3 R4 R5 R7: aligned delivery over two frames
   task automatic t_deliver(input logic [W-1:0] a, b, c);
      logic [W-1:0] e [3];
      e[0] = a; e[1] = b; e[2] = c;
      tx_user = {c, b, a};
      do_sync();
      for (int k = 0; k < 6; k++) begin
         int s = k % 3;
         chk(line_out == e[s], "R3 line_out slot word", line_out, e[s]);
         @(posedge clk);
         @(negedge clk);
         chk(rx_user == put(e[s], s), "R4 routed word", rx_user, put(e[s], s));
         chk(rx_valid == 3'(1 << s), "R5 valid strobe", rx_valid, 3'(1 << s));
         if (s == 2) begin
            chk(frame_valid == 1'b1, "R7 frame strobe", frame_valid, 1);
            chk(frame_out == {c, b, a}, "R7 frame words", frame_out, {c, b, a});
         end else begin
            chk(frame_valid == 1'b0, "R7 frame idle", frame_valid, 0);
         end
      end
   endtask

   // R3: unselected inputs do not reach the line
   task automatic t_isolation();
      tx_user = {8'h33, 8'h22, 8'h5A};
      do_sync();
      chk(line_out == 8'h5A, "R3 slot0 word", line_out, 8'h5A);
      tx_user[2*W-1:W] = 8'hC3;
      #0.5;
      chk(line_out == 8'h5A, "R3 user1 change ignored", line_out, 8'h5A);
      tx_user[3*W-1:2*W] = 8'h96;
      #0.5;
      chk(line_out == 8'h5A, "R3 user2 change ignored", line_out, 8'h5A);
      @(posedge clk);
      @(negedge clk);
      chk(rx_user == put(8'h5A, 0), "R3 delivered word", rx_user, put(8'h5A, 0));
   endtask

   // R6: sync in the middle of a frame
   task automatic t_sync_mid();
      tx_user = {8'h03, 8'h02, 8'h01};
      do_sync();
      @(posedge clk);
      @(negedge clk);
      chk(line_out == 8'h02, "R6 pre-sync slot1", line_out, 8'h02);
      sync = 1'b1;
      @(posedge clk);
      @(negedge clk);
      sync = 1'b0;
      chk(rx_user == put(8'h02, 1), "R6 slot1 delivered on sync edge", rx_user, put(8'h02, 1));
      chk(line_out == 8'h01, "R6 back to slot0", line_out, 8'h01);
      @(posedge clk);
      @(negedge clk);
      chk(rx_valid == 3'b001, "R6 next delivery slot0", rx_valid, 3'b001);
   endtask

   // R8: one-clock channel delay shifts each word by one user
   task automatic t_misalign();
      logic [W-1:0] e [3];
      e[0] = 8'hA1; e[1] = 8'hB2; e[2] = 8'hC3;
      tx_user = {e[2], e[1], e[0]};
      dly = 1'b1;
      do_sync();
      for (int k = 0; k < 6; k++) begin
         int s = k % 3;
         int src = (s + 2) % 3;
         @(posedge clk);
         @(negedge clk);
         if (k > 0)
            chk(rx_user == put(e[src], s), "R8 shifted delivery", rx_user, put(e[src], s));
      end
      dly = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_deliver(8'h11, 8'h22, 8'h33);
      t_deliver(8'hFF, 8'h00, 8'hA5);
      t_isolation();
      t_sync_mid();
      t_misalign();
      t_deliver(8'h3C, 8'hC3, 8'h7E);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule